// File: doc/BRIEF.md
# Remappable Memory Decoder with On-Chip SRAM

This block sits on the data side of a 32-bit processor bus and turns each byte-addressed request into an access to one of four targets. These are an internal 1024 x 32 SRAM, an external read-only flash array, a window of peripheral registers that is forwarded through a select/data port, and a low window starting at address zero. The low window aliases either the flash or the SRAM, so the exception vectors at the bottom of the map can come from either memory.

Requests carry an access size of 8, 16 or 32 bits. Write data is taken from the low bits of the write bus and placed on the byte lanes in little-endian order. Read data is shifted down and zero-extended. Every accepted request gets exactly one response one clock later. The response reports either the read data or an abort. An abort is raised for an unmapped address, a misaligned or illegal size, a write to flash, or a low-window address beyond the aliased memory. An aborted request changes no storage and selects no peripheral.

The flash contents live outside the block. The block drives a word index and captures the returned word at the request's clock edge.

Top module: `mem_remap_decoder`

## Requirements
- R1: During and after synchronous active-low reset, `rsp_valid` is 0, `remap_state` is 0 (low window aliases flash) and `per_sel` is 0.
- R2: The SRAM answers at byte addresses 0x00040000 to 0x00040FFF. A request in cycle N yields `rsp_valid`=1 in cycle N+1, and a cycle without a request yields `rsp_valid`=0 in the next cycle. A word read returns the last word written there.
- R3: Size code 0 is a byte, 1 a halfword and 2 a word. A byte or halfword write changes only the addressed bytes. Byte k of a word (address bits [1:0] = k) occupies data bits 8k+7:8k, and the written value is taken from the low bits of `req_wdata`.
- R4: A byte or halfword read returns the addressed bytes in the low bits of `rsp_rdata`, with the upper bits zero.
- R5: The flash window spans 0x00080000 to 0x00087FFF. A read there drives `flash_addr` with the byte offset divided by 4 in the request cycle, and returns the selected bytes of `flash_rdata` as sampled at that cycle's edge.
- R6: A cycle with `remap_wr`=1 loads `remap_val` into `remap_state` from the next cycle on. With 0, addresses 0x0 to 0x7FFF read flash at the same offset. With 1, addresses 0x0 to 0xFFF reach SRAM at the same offset, and 0x1000 to 0x7FFF abort.
- R7: An address in no region (including between and just past the regions) gives `rsp_abort`=1 and `rsp_rdata`=0 with the response.
- R8: A halfword at an odd address, a word at an address not a multiple of 4, or size code 3 aborts. An aborted request leaves SRAM unchanged and asserts no `per_sel`.
- R9: A write to the flash window, or to the low window while it aliases flash, aborts.
- R10: An address in 0xFFFF0000 to 0xFFFF0FFF raises `per_sel` in the request cycle, with `per_write`, `per_addr` = address minus 0xFFFF0000, `per_byte_en` set for the addressed bytes and `per_wdata` replicating the written byte or halfword across the word. `per_rdata` is sampled at the edge and returned like a memory read.
- R11: A write that does not abort gets a response with `rsp_abort`=0 and `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_wdata | input | 32 | Write data, sub-word values in low bits |
| remap_wr | input | 1 | Load strobe for the alias select |
| remap_val | input | 1 | New alias select: 0 flash, 1 SRAM |
| remap_state | output | 1 | Current alias select |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_abort | output | 1 | Request was rejected |
| rsp_rdata | output | 32 | Read data, zero-extended |
| flash_addr | output | 13 | Flash word index |
| flash_rdata | input | 32 | Flash word at `flash_addr` |
| per_sel | output | 1 | Peripheral register access this cycle |
| per_write | output | 1 | Peripheral access is a write |
| per_addr | output | 12 | Byte offset in the peripheral window |
| per_byte_en | output | 4 | Byte lanes of the peripheral access |
| per_wdata | output | 32 | Lane-steered peripheral write data |
| per_rdata | input | 32 | Peripheral read word |

## Verification
The bench builds the block with its default map: 1024 SRAM words at 0x40000, a 32 KB flash at 0x80000, a 4 KB peripheral window at 0xFFFF0000 and a 32 KB low window. With these values the last word of each region and the first byte past it are reachable with plain directed addresses. Under the SRAM alias, the low window is eight times larger than the SRAM, so the out-of-range alias abort can be exercised. A reference model outside the block holds the SRAM bytes and computes every expected abort and read word.

// File: rtl/mdec_pkg.sv
// Package: shared types for the remappable memory decoder.
// Assumes: size code 0/1/2 = byte/half/word, 3 is illegal.
package mdec_pkg;

    typedef enum logic [1:0] {
        RG_NONE  = 2'd0,
        RG_SRAM  = 2'd1,
        RG_FLASH = 2'd2,
        RG_PERI  = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    // Pull the addressed bytes of a word down to bit 0, zero-extended.
    function automatic logic [31:0] lane_extract(input logic [31:0] word,
                                                 input logic [1:0]  lane,
                                                 input size_e       size);
        logic [31:0] shifted;
        shifted = word >> {lane, 3'b000};
        case (size)
            SZ_BYTE: lane_extract = {24'h0, shifted[7:0]};
            SZ_HALF: lane_extract = {16'h0, shifted[15:0]};
            default: lane_extract = shifted;
        endcase
    endfunction

endpackage

// File: rtl/mdec_region_decode.sv
// Module: mdec_region_decode
// Maps a byte address onto a target region and a word index inside it,
// folds the low alias window onto flash or SRAM, and flags aborts.
// Assumes: regions do not overlap; all region sizes are powers of two.
module mdec_region_decode
    import mdec_pkg::*;
#(
    parameter logic [31:0] SRAM_BASE   = 32'h0004_0000,
    parameter int          SRAM_WORDS  = 1024,
    parameter logic [31:0] FLASH_BASE  = 32'h0008_0000,
    parameter int          FLASH_BYTES = 32768,
    parameter logic [31:0] PER_BASE    = 32'hFFFF_0000,
    parameter int          PER_BYTES   = 4096,
    parameter int          LOW_BYTES   = 32768,
    localparam int         SRAM_AW     = $clog2(SRAM_WORDS),
    localparam int         FLASH_AW    = $clog2(FLASH_BYTES / 4),
    localparam int         PER_AW      = $clog2(PER_BYTES)
) (
    input  logic [31:0]         addr,
    input  logic [1:0]          size,
    input  logic                write,
    input  logic                remap_sram,
    output region_e             region,
    output logic [SRAM_AW-1:0]  sram_idx,
    output logic [FLASH_AW-1:0] flash_idx,
    output logic [PER_AW-1:0]   per_off,
    output logic                abort
);

    localparam logic [31:0] SRAM_SPAN  = 32'(SRAM_WORDS * 4);
    localparam logic [31:0] FLASH_SPAN = 32'(FLASH_BYTES);
    localparam logic [31:0] PER_SPAN   = 32'(PER_BYTES);
    localparam logic [31:0] LOW_SPAN   = 32'(LOW_BYTES);

    logic [31:0] sram_rel, flash_rel, per_rel;
    logic        hit_sram, hit_flash, hit_per, hit_low;
    logic        misaligned;

    // Offsets relative to each region base; wraparound keeps the compare single-sided.
    assign sram_rel  = addr - SRAM_BASE;
    assign flash_rel = addr - FLASH_BASE;
    assign per_rel   = addr - PER_BASE;

    assign hit_sram  = sram_rel  < SRAM_SPAN;
    assign hit_flash = flash_rel < FLASH_SPAN;
    assign hit_per   = per_rel   < PER_SPAN;
    assign hit_low   = addr      < LOW_SPAN;

    // Pick the target region and its word index; alias folds onto the chosen memory.
    always_comb begin
        region    = RG_NONE;
        sram_idx  = sram_rel[SRAM_AW+1:2];
        flash_idx = flash_rel[FLASH_AW+1:2];
        per_off   = per_rel[PER_AW-1:0];
        if (hit_sram) begin
            region = RG_SRAM;
        end else if (hit_flash) begin
            region = RG_FLASH;
        end else if (hit_per) begin
            region = RG_PERI;
        end else if (hit_low) begin
            if (remap_sram) begin
                if (addr < SRAM_SPAN) begin
                    region   = RG_SRAM;
                    sram_idx = addr[SRAM_AW+1:2];
                end
            end else if (addr < FLASH_SPAN) begin
                region    = RG_FLASH;
                flash_idx = addr[FLASH_AW+1:2];
            end
        end
    end

    // Alignment rule per size code; code 3 is never legal.
    always_comb begin
        case (size_e'(size))
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = addr[0];
            SZ_WORD: misaligned = (addr[1:0] != 2'b00);
            default: misaligned = 1'b1;
        endcase
    end

    // Reject unmapped, misaligned and flash-write requests.
    assign abort = (region == RG_NONE) || misaligned ||
                   (write && (region == RG_FLASH));

endmodule

// File: rtl/mdec_lane_steer.sv
// Module: mdec_lane_steer
// Places sub-word write data on little-endian byte lanes and forms byte enables.
// Assumes: alignment already checked elsewhere; size code 3 yields no enables.
module mdec_lane_steer
    import mdec_pkg::*;
(
    input  logic [1:0]  size,
    input  logic [1:0]  lane,
    input  logic [31:0] wdata,
    output logic [3:0]  byte_en,
    output logic [31:0] wdata_lanes
);

    // Replicate the low bytes across the word and enable only the addressed lanes.
    always_comb begin
        case (size_e'(size))
            SZ_BYTE: begin
                wdata_lanes = {4{wdata[7:0]}};
                byte_en     = 4'b0001 << lane;
            end
            SZ_HALF: begin
                wdata_lanes = {2{wdata[15:0]}};
                byte_en     = 4'b0011 << {lane[1], 1'b0};
            end
            SZ_WORD: begin
                wdata_lanes = wdata;
                byte_en     = 4'b1111;
            end
            default: begin
                wdata_lanes = wdata;
                byte_en     = 4'b0000;
            end
        endcase
    end

endmodule

// File: rtl/mdec_sram.sv
// Module: mdec_sram
// Single-port SRAM built from one byte-wide array per lane, registered read.
// Assumes: read data is valid the cycle after an enabled access; contents are not reset.
module mdec_sram #(
    parameter int  WORDS = 1024,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [3:0]    be,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);

    for (genvar b = 0; b < 4; b++) begin : g_lane
        logic [7:0] mem [WORDS];
        logic [7:0] rq;

        // Write the lane when enabled and read it back one cycle later.
        always_ff @(posedge clk) begin
            if (en) begin
                if (we && be[b]) begin
                    mem[addr] <= wdata[8*b +: 8];
                end
                rq <= mem[addr];
            end
        end

        assign rdata[8*b +: 8] = rq;
    end

endmodule

// File: rtl/mem_remap_decoder.sv
// Module: mem_remap_decoder (top)
// Decodes bus requests onto SRAM, external flash, peripheral port or the low
// alias window; answers every request one cycle later with data or an abort.
// Assumes: flash_rdata and per_rdata are combinational from the address outputs.
module mem_remap_decoder
    import mdec_pkg::*;
#(
    parameter logic [31:0] SRAM_BASE   = 32'h0004_0000,
    parameter int          SRAM_WORDS  = 1024,
    parameter logic [31:0] FLASH_BASE  = 32'h0008_0000,
    parameter int          FLASH_BYTES = 32768,
    parameter logic [31:0] PER_BASE    = 32'hFFFF_0000,
    parameter int          PER_BYTES   = 4096,
    parameter int          LOW_BYTES   = 32768,
    localparam int         SRAM_AW     = $clog2(SRAM_WORDS),
    localparam int         FLASH_AW    = $clog2(FLASH_BYTES / 4),
    localparam int         PER_AW      = $clog2(PER_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [31:0]         req_addr,
    input  logic [1:0]          req_size,
    input  logic [31:0]         req_wdata,
    input  logic                remap_wr,
    input  logic                remap_val,
    output logic                remap_state,
    output logic                rsp_valid,
    output logic                rsp_abort,
    output logic [31:0]         rsp_rdata,
    output logic [FLASH_AW-1:0] flash_addr,
    input  logic [31:0]         flash_rdata,
    output logic                per_sel,
    output logic                per_write,
    output logic [PER_AW-1:0]   per_addr,
    output logic [3:0]          per_byte_en,
    output logic [31:0]         per_wdata,
    input  logic [31:0]         per_rdata
);

    region_e            region;
    logic [SRAM_AW-1:0] sram_idx;
    logic               dec_abort;
    logic [3:0]         lane_be;
    logic [31:0]        lane_wdata;
    logic               sram_en, sram_we;
    logic [31:0]        sram_rdata;

    // Response-stage state.
    logic               rd_q;
    region_e            region_q;
    logic [1:0]         lane_q;
    size_e              size_q;
    logic [31:0]        flash_q;
    logic [31:0]        per_q;

    mdec_region_decode #(
        .SRAM_BASE  (SRAM_BASE),
        .SRAM_WORDS (SRAM_WORDS),
        .FLASH_BASE (FLASH_BASE),
        .FLASH_BYTES(FLASH_BYTES),
        .PER_BASE   (PER_BASE),
        .PER_BYTES  (PER_BYTES),
        .LOW_BYTES  (LOW_BYTES)
    ) u_decode (
        .addr      (req_addr),
        .size      (req_size),
        .write     (req_write),
        .remap_sram(remap_state),
        .region    (region),
        .sram_idx  (sram_idx),
        .flash_idx (flash_addr),
        .per_off   (per_addr),
        .abort     (dec_abort)
    );

    mdec_lane_steer u_lanes (
        .size       (req_size),
        .lane       (req_addr[1:0]),
        .wdata      (req_wdata),
        .byte_en    (lane_be),
        .wdata_lanes(lane_wdata)
    );

    assign sram_en = req_valid && !dec_abort && (region == RG_SRAM);
    assign sram_we = sram_en && req_write;

    mdec_sram #(.WORDS(SRAM_WORDS)) u_sram (
        .clk  (clk),
        .en   (sram_en),
        .we   (sram_we),
        .be   (lane_be),
        .addr (sram_idx),
        .wdata(lane_wdata),
        .rdata(sram_rdata)
    );

    // Peripheral forwarding happens in the request cycle.
    assign per_sel     = req_valid && !dec_abort && (region == RG_PERI);
    assign per_write   = req_write;
    assign per_byte_en = per_sel ? lane_be : 4'b0000;
    assign per_wdata   = lane_wdata;

    // Alias select register, flash alias after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remap_state <= 1'b0;
        end else if (remap_wr) begin
            remap_state <= remap_val;
        end
    end

    // Response handshake: one response per request, one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_abort <= 1'b0;
            rd_q      <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_abort <= req_valid && dec_abort;
            rd_q      <= req_valid && !dec_abort && !req_write;
        end
    end

    // Capture read context and the external words of the request cycle.
    always_ff @(posedge clk) begin
        if (req_valid) begin
            region_q <= region;
            lane_q   <= req_addr[1:0];
            size_q   <= size_e'(req_size);
            flash_q  <= flash_rdata;
            per_q    <= per_rdata;
        end
    end

    // Select the source word and shift the addressed bytes down.
    always_comb begin
        rsp_rdata = 32'h0;
        if (rd_q) begin
            case (region_q)
                RG_SRAM:  rsp_rdata = lane_extract(sram_rdata, lane_q, size_q);
                RG_FLASH: rsp_rdata = lane_extract(flash_q, lane_q, size_q);
                RG_PERI:  rsp_rdata = lane_extract(per_q, lane_q, size_q);
                default:  rsp_rdata = 32'h0;
            endcase
        end
    end

    // ---------------- assertions ----------------
    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R6
    remap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remap_wr |=> (remap_state == $past(remap_val)));
    // R7
    abort_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_abort |-> (rsp_valid && rsp_rdata == 32'h0));
    // R8
    sram_wr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> (req_size != 2'd3) && !(req_size == 2'd1 && req_addr[0]) &&
                    !(req_size == 2'd2 && req_addr[1:0] != 2'b00));
    // R8
    abort_no_side_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_abort |-> $past(!sram_we && !per_sel));
    // R9
    flash_write_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && ((req_addr - FLASH_BASE) < 32'(FLASH_BYTES)))
        |=> rsp_abort);
    // R10
    per_sel_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_sel |-> ((req_addr - PER_BASE) < 32'(PER_BYTES)));
    // R3
    sram_be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> ($countones(lane_be) == (1 << req_size)));

endmodule

// File: tb/mem_remap_decoder_test.sv
module mem_remap_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = 32'h0, req_wdata = 32'h0;
    logic [1:0]  req_size = 2'd0;
    logic        remap_wr = 1'b0, remap_val = 1'b0;
    logic        remap_state, rsp_valid, rsp_abort;
    logic [31:0] rsp_rdata;
    logic [12:0] flash_addr;
    logic [31:0] flash_rdata;
    logic        per_sel, per_write;
    logic [11:0] per_addr;
    logic [3:0]  per_byte_en;
    logic [31:0] per_wdata, per_rdata;

    int checks = 0;
    int errors = 0;

    logic [31:0] smem [1024];
    bit          remap_m = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [31:0] flash_word(input logic [12:0] i);
        return 32'hF1A5_0000 ^ ({19'h0, i} * 32'h0001_0011);
    endfunction

    assign flash_rdata = flash_word(flash_addr);
    assign per_rdata   = 32'hC0DE_5000 | {20'h0, per_addr};

    mem_remap_decoder uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .remap_wr(remap_wr), .remap_val(remap_val), .remap_state(remap_state),
        .rsp_valid(rsp_valid), .rsp_abort(rsp_abort), .rsp_rdata(rsp_rdata),
        .flash_addr(flash_addr), .flash_rdata(flash_rdata),
        .per_sel(per_sel), .per_write(per_write), .per_addr(per_addr),
        .per_byte_en(per_byte_en), .per_wdata(per_wdata), .per_rdata(per_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference decode from the requirements: region 0 none, 1 SRAM, 2 flash, 3 peripheral.
    function automatic void ref_map(input logic [31:0] a, input logic [1:0] sz,
                                    input bit wr, input bit rm, output int rg,
                                    output logic [31:0] off, output bit ab);
        rg = 0; off = 0;
        if (a >= 32'h0004_0000 && a < 32'h0004_1000) begin rg = 1; off = a - 32'h0004_0000; end
        else if (a >= 32'h0008_0000 && a < 32'h0008_8000) begin rg = 2; off = a - 32'h0008_0000; end
        else if (a >= 32'hFFFF_0000 && a <= 32'hFFFF_0FFF) begin rg = 3; off = a - 32'hFFFF_0000; end
        else if (a < 32'h0000_8000) begin
            if (rm) begin
                if (a < 32'h1000) begin rg = 1; off = a; end
            end else begin
                rg = 2; off = a;
            end
        end
        ab = (rg == 0) || (sz == 2'd3) || (sz == 2'd1 && a[0]) ||
             (sz == 2'd2 && a[1:0] != 2'b00) || (wr && rg == 2);
    endfunction

    // One request, its forwarding outputs, its response and the model update.
    task automatic access(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input string tag);
        int          rg;
        logic [31:0] off, word, exp, shifted;
        logic [3:0]  be;
        bit          ab;
        ref_map(a, sz, wr, remap_m, rg, off, ab);
        case (sz)
            2'd0: be = 4'b0001 << a[1:0];
            2'd1: be = 4'b0011 << a[1:0];
            default: be = 4'b1111;
        endcase
        case (rg)
            1: word = smem[off[11:2]];
            2: word = flash_word(off[14:2]);
            3: word = 32'hC0DE_5000 | {20'h0, off[11:0]};
            default: word = 32'h0;
        endcase
        shifted = word >> (8 * a[1:0]);
        exp = (sz == 2'd0) ? {24'h0, shifted[7:0]} :
              (sz == 2'd1) ? {16'h0, shifted[15:0]} : shifted;
        if (wr || ab) exp = 32'h0;

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        #2;
        chk(per_sel == (rg == 3 && !ab), ab ? "R8" : "R10", {31'h0, per_sel},
            {31'h0, (rg == 3 && !ab)});
        if (rg == 3 && !ab) begin
            chk(per_addr == off[11:0] && per_write == wr && per_byte_en == be,
                "R10", {15'h0, per_write, per_byte_en, per_addr}, {15'h0, wr, be, off[11:0]});
            if (wr)
                chk(per_wdata == ((sz == 2'd0) ? {4{wd[7:0]}} : (sz == 2'd1) ? {2{wd[15:0]}} : wd),
                    "R10", per_wdata, wd);
        end
        if (rg == 2 && !ab)
            chk(flash_addr == off[14:2], "R5", {19'h0, flash_addr}, {19'h0, off[14:2]});

        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(rsp_valid == 1'b1, "R2", {31'h0, rsp_valid}, 32'h1);
        chk(rsp_abort == ab, tag, {31'h0, rsp_abort}, {31'h0, ab});
        chk(rsp_rdata == exp, (wr && !ab) ? "R11" : tag, rsp_rdata, exp);

        if (wr && !ab && rg == 1) begin
            for (int k = 0; k < 4; k++)
                if (be[k])
                    smem[off[11:2]][8*k +: 8] = (sz == 2'd0) ? wd[7:0] :
                                                (sz == 2'd1) ? wd[8*(k - a[1]*2) +: 8] :
                                                               wd[8*k +: 8];
        end
    endtask

    task automatic set_remap(input bit v);
        @(negedge clk);
        remap_wr = 1'b1; remap_val = v;
        @(negedge clk);
        remap_wr = 1'b0;
        chk(remap_state == v, "R6", {31'h0, remap_state}, {31'h0, v});
        remap_m = v;
    endtask

    task automatic t_reset;
        chk(rsp_valid == 1'b0, "R1", {31'h0, rsp_valid}, 32'h0);
        chk(remap_state == 1'b0, "R1", {31'h0, remap_state}, 32'h0);
        chk(per_sel == 1'b0, "R1", {31'h0, per_sel}, 32'h0);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2", {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic t_sram_words;
        for (int i = 0; i < 1024; i++) smem[i] = 32'h0;
        for (int i = 0; i < 1024; i++) access(1'b1, 32'h0004_0000 + 32'(i * 4), 2'd2, 32'h0, "R2");
        access(1'b1, 32'h0004_0000, 2'd2, 32'hDEAD_BEEF, "R2");
        access(1'b1, 32'h0004_0FFC, 2'd2, 32'h1234_5678, "R2");
        access(1'b0, 32'h0004_0000, 2'd2, 32'h0, "R2");
        access(1'b0, 32'h0004_0FFC, 2'd2, 32'h0, "R2");
    endtask

    task automatic t_subword;
        access(1'b1, 32'h0004_0010, 2'd2, 32'hAABB_CCDD, "R3");
        access(1'b1, 32'h0004_0011, 2'd0, 32'hFFFF_FF5A, "R3");
        access(1'b1, 32'h0004_0012, 2'd1, 32'h0000_9876, "R3");
        access(1'b0, 32'h0004_0010, 2'd2, 32'h0, "R3");
        access(1'b0, 32'h0004_0013, 2'd0, 32'h0, "R4");
        access(1'b0, 32'h0004_0011, 2'd0, 32'h0, "R4");
        access(1'b0, 32'h0004_0010, 2'd1, 32'h0, "R4");
        access(1'b0, 32'h0004_0FFE, 2'd1, 32'h0, "R4");
    endtask

    task automatic t_flash;
        access(1'b0, 32'h0008_0000, 2'd2, 32'h0, "R5");
        access(1'b0, 32'h0008_7FFC, 2'd2, 32'h0, "R5");
        access(1'b0, 32'h0008_0005, 2'd0, 32'h0, "R5");
        access(1'b0, 32'h0008_1236, 2'd1, 32'h0, "R5");
    endtask

    task automatic t_remap;
        access(1'b0, 32'h0000_0000, 2'd2, 32'h0, "R6");
        access(1'b0, 32'h0000_7FFC, 2'd2, 32'h0, "R6");
        set_remap(1'b1);
        access(1'b0, 32'h0000_0000, 2'd2, 32'h0, "R6");
        access(1'b1, 32'h0000_0008, 2'd2, 32'h0BAD_F00D, "R6");
        access(1'b0, 32'h0004_0008, 2'd2, 32'h0, "R6");
        access(1'b0, 32'h0000_0FFC, 2'd2, 32'h0, "R6");
        access(1'b0, 32'h0000_1000, 2'd2, 32'h0, "R6");
        set_remap(1'b0);
        access(1'b0, 32'h0000_0008, 2'd2, 32'h0, "R6");
    endtask

    task automatic t_unmapped;
        access(1'b0, 32'h0000_8000, 2'd2, 32'h0, "R7");
        access(1'b0, 32'h0003_FFFC, 2'd2, 32'h0, "R7");
        access(1'b1, 32'h0004_1000, 2'd2, 32'h5, "R7");
        access(1'b0, 32'h0008_8000, 2'd0, 32'h0, "R7");
        access(1'b0, 32'hFFFE_FFFC, 2'd2, 32'h0, "R7");
        access(1'b0, 32'hFFFF_1000, 2'd2, 32'h0, "R7");
    endtask

    task automatic t_misaligned;
        access(1'b1, 32'h0004_0021, 2'd1, 32'h0000_1111, "R8");
        access(1'b1, 32'h0004_0022, 2'd2, 32'h2222_2222, "R8");
        access(1'b1, 32'h0004_0020, 2'd3, 32'h3333_3333, "R8");
        access(1'b0, 32'h0004_0020, 2'd2, 32'h0, "R8");
        access(1'b1, 32'hFFFF_0002, 2'd2, 32'h4444_4444, "R8");
        access(1'b0, 32'h0008_0003, 2'd1, 32'h0, "R8");
    endtask

    task automatic t_flash_write;
        access(1'b1, 32'h0008_0000, 2'd2, 32'h7777_7777, "R9");
        access(1'b1, 32'h0000_0004, 2'd0, 32'h77, "R9");
        access(1'b0, 32'h0008_0000, 2'd2, 32'h0, "R9");
    endtask

    task automatic t_peri;
        access(1'b0, 32'hFFFF_0000, 2'd2, 32'h0, "R10");
        access(1'b1, 32'hFFFF_0123, 2'd0, 32'h0000_00A7, "R10");
        access(1'b1, 32'hFFFF_0FFE, 2'd1, 32'h0000_C3C3, "R10");
        access(1'b0, 32'hFFFF_0FFE, 2'd1, 32'h0, "R10");
        access(1'b0, 32'hFFFF_0FFF, 2'd0, 32'h0, "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sram_words();
        t_subword();
        t_flash();
        t_remap();
        t_unmapped();
        t_misaligned();
        t_flash_write();
        t_peri();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule